// File: doc/BRIEF.md
# Dual-Clock Mailbox Pair

This block gives two independently clocked ports a way to hand single 36-bit words to each other outside the main data queue. It holds two one-word mailboxes that run in opposite directions. Port A loads mailbox 1 and port B takes from it. Port B loads mailbox 2 and port A takes from it. Each mailbox has an active-low full flag. The flag lives in the writer's clock domain, is pulled low by an accepted write, and is returned high once the reader has taken the word. While the flag is low, further writes to that mailbox are dropped, so an unread word is never overwritten.

Each port has a single direction select and a mailbox select. When the mailbox select is low, the port works on the queue path, and that path is seen here only as an external data input that the output mux can pick. When a port is in its read direction it asserts an output-enable, which an external pad or bus driver uses for its tri-state control. While the output-enable is asserted, the port's data output shows either the incoming mailbox or the queue word. The flags cross between the two domains as toggle tokens, each passed through a synchronizer of two flops.

Top module: `xdom_mailbox_pair`

## Requirements
- R1: On a rising `clk_a` edge with `a_wr_rd`=1, `a_mbx_sel`=1 and `mb1_full_n`=1, mailbox 1 captures `a_din`, and `mb1_full_n` reads 0 right after that same edge.
- R2: While `mb1_full_n`=0, port A writes to mailbox 1 are dropped. The word later read on port B is the first one written, and the flag stays 0.
- R3: On a rising `clk_b` edge with `b_rd_wr`=1 and `b_mbx_sel`=1, while port B sees mailbox 1 as full, the mailbox is released, and `mb1_full_n` returns to 1 within four `clk_a` edges.
- R4: Mailbox 2 works the same way in the other direction. A `clk_b` edge with `b_rd_wr`=0 and `b_mbx_sel`=1 stores `b_din` and drives `mb2_full_n` to 0. Further port B writes are dropped while that flag is 0. A `clk_a` edge with `a_wr_rd`=0 and `a_mbx_sel`=1 releases the mailbox, and the flag returns to 1.
- R5: `mb1_full_n` is 1 while `rst_b_n` or `prst_n` is low, and it stays 1 after the release. `mb2_full_n` is 1 while `rst_a_n` or `prst_n` is low. A reset that belongs to one mailbox leaves the other mailbox's flag unchanged.
- R6: `b_oe`=`b_rd_wr`, so port B drives only in its read direction (1 = read, 0 = write). While `b_oe`=1, `b_dout` shows mailbox 1 when `b_mbx_sel`=1 and `b_fifo_q` when `b_mbx_sel`=0.
- R7: `a_oe`=NOT `a_wr_rd`, so port A drives only in its read direction (1 = write, 0 = read). While `a_oe`=1, `a_dout` shows mailbox 2 when `a_mbx_sel`=1 and `a_fifo_q` when `a_mbx_sel`=0.
- R8: A read with the mailbox select high while the reader already sees that mailbox as empty still shows the stored word, and it leaves the flag at 1. The next write is accepted normally.
- R9: A write with the mailbox select low goes to the queue path and leaves the mailbox flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a_n | input | 1 | Port A side reset, active low; clears mailbox 2 |
| clk_b | input | 1 | Port B clock |
| rst_b_n | input | 1 | Port B side reset, active low; clears mailbox 1 |
| prst_n | input | 1 | Partial reset, active low; clears both mailboxes |
| a_wr_rd | input | 1 | Port A direction: 1 write, 0 read |
| a_mbx_sel | input | 1 | Port A selects a mailbox (1) or the queue path (0) |
| a_din | input | 36 | Port A write data |
| a_fifo_q | input | 36 | Queue word offered on port A |
| a_dout | output | 36 | Port A read data |
| a_oe | output | 1 | Port A output enable |
| mb1_full_n | output | 1 | Mailbox 1 full flag, active low, `clk_a` domain |
| b_rd_wr | input | 1 | Port B direction: 1 read, 0 write |
| b_mbx_sel | input | 1 | Port B selects a mailbox (1) or the queue path (0) |
| b_din | input | 36 | Port B write data |
| b_fifo_q | input | 36 | Queue word offered on port B |
| b_dout | output | 36 | Port B read data |
| b_oe | output | 1 | Port B output enable |
| mb2_full_n | output | 1 | Mailbox 2 full flag, active low, `clk_b` domain |

## Verification
A clear token that is lost or duplicated shows up as a flag stuck low. Writes on the writer's port then stop being accepted, and this is visible about four writer clocks after the read. A stray toggle instead lets the flag rise while the word is still unread, so the next write replaces a word that was never read. The scoreboard catches this on the following read. A wrong capture enable or a wrong output mux shows up at once as a wrong word on the reader's data output during the read cycle. A mis-routed reset shows up as a flag that stays low through the reset that should clear it, or as the wrong mailbox being cleared.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned MBX_W_DEF    = 36;
  localparam int unsigned MBX_SYNC_DEF = 2;

  // decoded mailbox operation of one port for the current edge
  typedef struct packed {
    logic wr;
    logic rd;
  } mbx_op_t;

  function automatic mbx_op_t mbx_decode(input logic is_wr, input logic sel);
    mbx_op_t op;
    op.wr = sel & is_wr;
    op.rd = sel & ~is_wr;
    return op;
  endfunction
endpackage

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_nxt;

  always_comb begin
    sh_nxt = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_nxt;
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/mbx_bit_sync.sv
module mbx_bit_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_nxt;

  always_comb begin
    sh_nxt = {sh_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_nxt;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/mbx_channel.sv
// One single-word mailbox from a writer clock domain to a reader clock domain.
module mbx_channel #(
  parameter int unsigned W    = 36,
  parameter int unsigned SYNC = 2
) (
  input  logic         wclk,
  input  logic         rclk,
  input  logic         arst_n,
  input  logic         wr_req,
  input  logic [W-1:0] wdata,
  input  logic         rd_req,
  output logic [W-1:0] rdata,
  output logic         full_n,
  output logic         wrst_n
);
  logic         rrst_n;
  logic         set_tok_q, set_tok_nxt;
  logic         clr_tok_q, clr_tok_nxt;
  logic         clr_seen_w, set_seen_r;
  logic         wr_take, rd_take, avail_r;
  logic [W-1:0] word_q, word_nxt;

  mbx_rst_sync #(.STAGES(SYNC)) u_wrst (.clk(wclk), .arst_n(arst_n), .srst_n(wrst_n));
  mbx_rst_sync #(.STAGES(SYNC)) u_rrst (.clk(rclk), .arst_n(arst_n), .srst_n(rrst_n));

  // writer domain
  mbx_bit_sync #(.STAGES(SYNC)) u_clr2w (
    .clk(wclk), .rst_n(wrst_n), .d(clr_tok_q), .q(clr_seen_w));

  always_comb begin
    full_n      = (set_tok_q == clr_seen_w);
    wr_take     = wr_req & full_n;
    set_tok_nxt = set_tok_q ^ wr_take;
    word_nxt    = wr_take ? wdata : word_q;
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) set_tok_q <= 1'b0;
    else         set_tok_q <= set_tok_nxt;
  end

  always_ff @(posedge wclk) begin
    word_q <= word_nxt;
  end

  // reader domain
  mbx_bit_sync #(.STAGES(SYNC)) u_set2r (
    .clk(rclk), .rst_n(rrst_n), .d(set_tok_q), .q(set_seen_r));

  always_comb begin
    avail_r     = (set_seen_r != clr_tok_q);
    rd_take     = rd_req & avail_r;
    clr_tok_nxt = clr_tok_q ^ rd_take;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) clr_tok_q <= 1'b0;
    else         clr_tok_q <= clr_tok_nxt;
  end

  assign rdata = word_q;
endmodule

// File: rtl/mbx_port.sv
// Direction decode, output enable and read mux of one port.
module mbx_port
  import mbx_pkg::*;
#(
  parameter int unsigned W      = 36,
  parameter bit          WR_LVL = 1'b1
) (
  input  logic         wr_rd,
  input  logic         mbx_sel,
  input  logic [W-1:0] mbx_q,
  input  logic [W-1:0] fifo_q,
  output logic [W-1:0] dout,
  output logic         oe,
  output mbx_op_t      op
);
  logic is_wr;

  always_comb begin
    is_wr = (wr_rd == WR_LVL);
    oe    = ~is_wr;
    dout  = mbx_sel ? mbx_q : fifo_q;
    op    = mbx_decode(is_wr, mbx_sel);
  end
endmodule

// File: rtl/xdom_mailbox_pair.sv
module xdom_mailbox_pair
  import mbx_pkg::*;
#(
  parameter int unsigned W    = MBX_W_DEF,
  parameter int unsigned SYNC = MBX_SYNC_DEF
) (
  input  logic         clk_a,
  input  logic         rst_a_n,
  input  logic         clk_b,
  input  logic         rst_b_n,
  input  logic         prst_n,
  input  logic         a_wr_rd,
  input  logic         a_mbx_sel,
  input  logic [W-1:0] a_din,
  input  logic [W-1:0] a_fifo_q,
  output logic [W-1:0] a_dout,
  output logic         a_oe,
  output logic         mb1_full_n,
  input  logic         b_rd_wr,
  input  logic         b_mbx_sel,
  input  logic [W-1:0] b_din,
  input  logic [W-1:0] b_fifo_q,
  output logic [W-1:0] b_dout,
  output logic         b_oe,
  output logic         mb2_full_n
);
  localparam int unsigned NMBX = 2;

  mbx_op_t                  op_a, op_b;
  logic [NMBX-1:0]          wclk_v, rclk_v, arst_v, wr_v, rd_v, full_v, wrst_v;
  logic [NMBX-1:0][W-1:0]   wdat_v, mb_q;

  // index 0: mailbox 1 (A -> B); index 1: mailbox 2 (B -> A)
  assign wclk_v = {clk_b, clk_a};
  assign rclk_v = {clk_a, clk_b};
  assign arst_v = {rst_a_n & prst_n, rst_b_n & prst_n};
  assign wr_v   = {op_b.wr, op_a.wr};
  assign rd_v   = {op_a.rd, op_b.rd};
  assign wdat_v = {b_din, a_din};

  mbx_port #(.W(W), .WR_LVL(1'b1)) u_port_a (
    .wr_rd(a_wr_rd), .mbx_sel(a_mbx_sel), .mbx_q(mb_q[1]), .fifo_q(a_fifo_q),
    .dout(a_dout), .oe(a_oe), .op(op_a));

  mbx_port #(.W(W), .WR_LVL(1'b0)) u_port_b (
    .wr_rd(b_rd_wr), .mbx_sel(b_mbx_sel), .mbx_q(mb_q[0]), .fifo_q(b_fifo_q),
    .dout(b_dout), .oe(b_oe), .op(op_b));

  for (genvar gi = 0; gi < NMBX; gi++) begin : g_mbx
    mbx_channel #(.W(W), .SYNC(SYNC)) u_chan (
      .wclk(wclk_v[gi]), .rclk(rclk_v[gi]), .arst_n(arst_v[gi]),
      .wr_req(wr_v[gi]), .wdata(wdat_v[gi]), .rd_req(rd_v[gi]),
      .rdata(mb_q[gi]), .full_n(full_v[gi]), .wrst_n(wrst_v[gi]));
  end

  assign mb1_full_n = full_v[0];
  assign mb2_full_n = full_v[1];
endmodule

// File: rtl/mbx_pair_chk.sv
module mbx_pair_chk #(
  parameter int unsigned W = 36
) (
  input logic         clk_a,
  input logic         clk_b,
  input logic         rst_a_n,
  input logic         rst_b_n,
  input logic         prst_n,
  input logic         a_wr_rd,
  input logic         a_mbx_sel,
  input logic         b_rd_wr,
  input logic         b_mbx_sel,
  input logic         b_oe,
  input logic [W-1:0] b_dout,
  input logic         mb1_full_n,
  input logic         mb2_full_n,
  input logic [1:0]   wrst_n,
  input logic [W-1:0] mb1_q,
  input logic [W-1:0] mb2_q
);
  AST_MB1_WRITE_SETS: assert property (@(posedge clk_a) disable iff (!wrst_n[0])
    (a_wr_rd && a_mbx_sel && mb1_full_n) |=> !mb1_full_n); // R1

  AST_MB1_FULL_HOLDS: assert property (@(posedge clk_a) disable iff (!wrst_n[0])
    !mb1_full_n |=> $stable(mb1_q)); // R2

  AST_MB2_WRITE_SETS: assert property (@(posedge clk_b) disable iff (!wrst_n[1])
    (!b_rd_wr && b_mbx_sel && mb2_full_n) |=> !mb2_full_n); // R4

  AST_MB2_FULL_HOLDS: assert property (@(posedge clk_b) disable iff (!wrst_n[1])
    !mb2_full_n |=> $stable(mb2_q)); // R4

  AST_MB1_RESET_HIGH: assert property (@(posedge clk_b)
    !(rst_b_n && prst_n) |-> mb1_full_n); // R5

  AST_MB2_RESET_HIGH: assert property (@(posedge clk_a)
    !(rst_a_n && prst_n) |-> mb2_full_n); // R5

  AST_B_SHOWS_MBX: assert property (@(posedge clk_b) disable iff (!prst_n)
    (b_oe && b_mbx_sel) |-> (b_dout == mb1_q)); // R6
endmodule

bind xdom_mailbox_pair mbx_pair_chk #(.W(W)) u_chk (
  .clk_a(clk_a), .clk_b(clk_b), .rst_a_n(rst_a_n), .rst_b_n(rst_b_n), .prst_n(prst_n),
  .a_wr_rd(a_wr_rd), .a_mbx_sel(a_mbx_sel), .b_rd_wr(b_rd_wr), .b_mbx_sel(b_mbx_sel),
  .b_oe(b_oe), .b_dout(b_dout), .mb1_full_n(mb1_full_n), .mb2_full_n(mb2_full_n),
  .wrst_n(wrst_v), .mb1_q(mb_q[0]), .mb2_q(mb_q[1]));

// File: tb/tb_xdom_mailbox_pair.sv
`timescale 1ns/1ps
module tb_xdom_mailbox_pair;
  localparam int W = 36;

  logic clk_a = 1'b0, clk_b = 1'b0;
  logic rst_a_n, rst_b_n, prst_n;
  logic a_wr_rd, a_mbx_sel, b_rd_wr, b_mbx_sel;
  logic [W-1:0] a_din, a_fifo_q, b_din, b_fifo_q, a_dout, b_dout;
  logic a_oe, b_oe, mb1_full_n, mb2_full_n;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  bit a_expect = 1'b0, b_expect = 1'b0;
  logic [W-1:0] q_mb1[$];
  logic [W-1:0] q_mb2[$];

  always #4   clk_a = ~clk_a;  // 125 MHz
  always #5.5 clk_b = ~clk_b;

  xdom_mailbox_pair dut (
    .clk_a(clk_a), .rst_a_n(rst_a_n), .clk_b(clk_b), .rst_b_n(rst_b_n), .prst_n(prst_n),
    .a_wr_rd(a_wr_rd), .a_mbx_sel(a_mbx_sel), .a_din(a_din), .a_fifo_q(a_fifo_q),
    .a_dout(a_dout), .a_oe(a_oe), .mb1_full_n(mb1_full_n),
    .b_rd_wr(b_rd_wr), .b_mbx_sel(b_mbx_sel), .b_din(b_din), .b_fifo_q(b_fifo_q),
    .b_dout(b_dout), .b_oe(b_oe), .mb2_full_n(mb2_full_n));

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitors: pop expected mailbox words as the reads happen
  always begin
    @(negedge clk_b); #2;
    if (b_expect) begin
      if (q_mb1.size() == 0) chk("R1 scoreboard underflow mb1", 1, 0);
      else chk("R1/R2 port B mailbox 1 word", b_dout, q_mb1.pop_front());
    end
  end

  always begin
    @(negedge clk_a); #2;
    if (a_expect) begin
      if (q_mb2.size() == 0) chk("R4 scoreboard underflow mb2", 1, 0);
      else chk("R4/R7 port A mailbox 2 word", a_dout, q_mb2.pop_front());
    end
  end

  task automatic a_write(input logic [W-1:0] v, input logic sel);
    @(negedge clk_a); a_wr_rd = 1'b1; a_mbx_sel = sel; a_din = v;
    @(negedge clk_a); a_wr_rd = 1'b0; a_mbx_sel = 1'b0;
  endtask

  task automatic b_write(input logic [W-1:0] v);
    @(negedge clk_b); b_rd_wr = 1'b0; b_mbx_sel = 1'b1; b_din = v;
    @(negedge clk_b); b_rd_wr = 1'b1; b_mbx_sel = 1'b0;
  endtask

  task automatic b_read_sb();
    @(negedge clk_b); b_mbx_sel = 1'b1; b_expect = 1'b1;
    @(negedge clk_b); b_mbx_sel = 1'b0; b_expect = 1'b0;
  endtask

  task automatic a_read_sb();
    @(negedge clk_a); a_mbx_sel = 1'b1; a_expect = 1'b1;
    @(negedge clk_a); a_mbx_sel = 1'b0; a_expect = 1'b0;
  endtask

  task automatic wait_a(input int n); repeat (n) @(negedge clk_a); endtask
  task automatic wait_b(input int n); repeat (n) @(negedge clk_b); endtask

  initial begin
    repeat (20000) @(posedge clk_a);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_a_n = 0; rst_b_n = 0; prst_n = 0;
    a_wr_rd = 0; a_mbx_sel = 0; a_din = '0; a_fifo_q = 36'h0_A5A5_A5A5;
    b_rd_wr = 1; b_mbx_sel = 0; b_din = '0; b_fifo_q = 36'h0_5A5A_5A5A;
    wait_a(3); #1;
    chk("R5 mb1 flag in reset", mb1_full_n, 1);
    chk("R5 mb2 flag in reset", mb2_full_n, 1);
    rst_a_n = 1; rst_b_n = 1; prst_n = 1;
    wait_a(6); wait_b(6);

    // queue path outputs
    #1;
    chk("R7 a_oe in read", a_oe, 1);
    chk("R7 a_dout queue word", a_dout, 36'h0_A5A5_A5A5);
    chk("R6 b_oe in read", b_oe, 1);
    chk("R6 b_dout queue word", b_dout, 36'h0_5A5A_5A5A);
    @(negedge clk_b); b_rd_wr = 1'b0; #1;
    chk("R6 b_oe off in write", b_oe, 0);
    b_rd_wr = 1'b1;
    @(negedge clk_a); a_wr_rd = 1'b1; #1;
    chk("R7 a_oe off in write", a_oe, 0);
    a_wr_rd = 1'b0;

    // R9: queue write leaves mailbox alone
    a_write(36'h1_1111_1111, 1'b0); #1;
    chk("R9 mb1 flag after queue write", mb1_full_n, 1);

    // R1 / R2
    a_write(36'h9_DEAD_BEEF, 1'b1); #1;
    q_mb1.push_back(36'h9_DEAD_BEEF);
    chk("R1 mb1 flag low after write", mb1_full_n, 0);
    a_write(36'h2_2222_2222, 1'b1); #1;
    chk("R2 mb1 flag stays low", mb1_full_n, 0);
    wait_b(4);
    b_read_sb();
    wait_a(5); #1;
    chk("R3 mb1 flag released", mb1_full_n, 1);

    // R8: repeated read of empty mailbox
    @(negedge clk_b); b_mbx_sel = 1'b1; #1;
    chk("R8 empty read still shows word", b_dout, 36'h9_DEAD_BEEF);
    @(negedge clk_b); b_mbx_sel = 1'b0;
    wait_a(5); #1;
    chk("R8 flag untouched by empty read", mb1_full_n, 1);
    a_write(36'h3_0BAD_F00D, 1'b1); #1;
    q_mb1.push_back(36'h3_0BAD_F00D);
    chk("R8 next write accepted", mb1_full_n, 0);
    wait_b(4);
    b_read_sb();
    wait_a(5); #1;
    chk("R3 mb1 flag released again", mb1_full_n, 1);

    // R4: mailbox 2
    b_write(36'h4_CAFE_0001); #1;
    q_mb2.push_back(36'h4_CAFE_0001);
    chk("R4 mb2 flag low after write", mb2_full_n, 0);
    b_write(36'h4_CAFE_0002); #1;
    chk("R4 mb2 flag stays low", mb2_full_n, 0);
    wait_a(4);
    a_read_sb();
    wait_b(5); #1;
    chk("R4 mb2 flag released", mb2_full_n, 1);

    // R5: partial reset clears both
    a_write(36'h5_0000_0005, 1'b1);
    b_write(36'h5_0000_0006); #1;
    chk("R5 setup mb1 full", mb1_full_n, 0);
    chk("R5 setup mb2 full", mb2_full_n, 0);
    @(negedge clk_a); prst_n = 1'b0; #1;
    chk("R5 mb1 high on partial reset", mb1_full_n, 1);
    chk("R5 mb2 high on partial reset", mb2_full_n, 1);
    wait_a(3); prst_n = 1'b1;
    wait_a(6); wait_b(6); #1;
    chk("R5 mb1 high after partial reset", mb1_full_n, 1);
    chk("R5 mb2 high after partial reset", mb2_full_n, 1);

    // R5: side resets are mailbox specific
    a_write(36'h6_0000_0007, 1'b1);
    b_write(36'h6_0000_0008);
    @(negedge clk_b); rst_b_n = 1'b0; #1;
    chk("R5 mb1 high on port B reset", mb1_full_n, 1);
    chk("R5 mb2 kept on port B reset", mb2_full_n, 0);
    wait_b(3); rst_b_n = 1'b1;
    wait_a(6); wait_b(6);
    @(negedge clk_a); rst_a_n = 1'b0; #1;
    chk("R5 mb2 high on port A reset", mb2_full_n, 1);
    wait_a(3); rst_a_n = 1'b1;
    wait_a(6); wait_b(6);

    // mailbox usable after resets
    a_write(36'h7_1234_5678, 1'b1); #1;
    q_mb1.push_back(36'h7_1234_5678);
    chk("R1 write after reset", mb1_full_n, 0);
    wait_b(4);
    b_read_sb();
    wait_a(5); #1;
    chk("R3 release after reset", mb1_full_n, 1);
    chk("R2 scoreboard drained", q_mb1.size() + q_mb2.size(), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule